// File: doc/BRIEF.md
# Selectable-Mode Parity Error Tally

This block keeps performance-monitoring tallies of parity errors for two overhead parity bytes of a synchronous optical frame stream: the section parity byte and the line parity byte. Once per frame an upstream stage pulses a one-cycle frame strobe. With it come, for each byte, the parity value computed locally over the frame and the parity value received in the overhead. The block XORs each pair into an error mask and adds an amount to a dedicated 16-bit error counter.

Each counter has its own mode bit, which the host can change at run time. In bit mode the counter grows by the number of mismatched bit positions. In frame mode it grows by one for every frame whose mask is non-zero. Counters saturate rather than wrap. A host read strobe per counter returns the current value and clears it. An error arriving in the same cycle as the read is added to the cleared value, so no error is lost.

Top module: `bip_err_tally`

## Requirements
- R1: While `rst` is high at a clock edge, both counters become 0.
- R2: The error mask is calc XOR rcvd. A frame whose mask is zero adds nothing in either mode.
- R3: With the mode bit at 0 (bit mode), a frame strobe adds the number of 1 bits in the mask (0 to 8).
- R4: With the mode bit at 1 (frame mode), a frame strobe with a non-zero mask adds exactly 1.
- R5: The section and line lanes are independent. Each has its own parity inputs, mode bit, read strobe and counter.
- R6: Without `frame_stb` and without a read strobe, a counter holds its value whatever the parity and mode inputs do.
- R7: A counter saturates at 65535 and stays there under further errors until it is read.
- R8: During a read-strobe cycle the counter port shows the accumulated value. On the next cycle the counter equals the increment of any same-cycle frame strobe (0 if none).
- R9: The mode bit is sampled in the frame-strobe cycle. A change applies to the first strobe at or after the change.
- R10: A frame strobe's increment appears on the counter port in the cycle after the strobe's clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe: parity values below are valid |
| sec_calc | input | 8 | Locally computed section parity |
| sec_rcvd | input | 8 | Received section parity |
| line_calc | input | 8 | Locally computed line parity |
| line_rcvd | input | 8 | Received line parity |
| sec_mode | input | 1 | Section tally mode: 0 bits, 1 frames |
| line_mode | input | 1 | Line tally mode: 0 bits, 1 frames |
| sec_rd | input | 1 | Read-and-clear strobe for the section counter |
| line_rd | input | 1 | Read-and-clear strobe for the line counter |
| sec_count | output | 16 | Section error counter |
| line_count | output | 16 | Line error counter |

## Verification
On every cycle the assertions check the following properties. A counter stays still when it is neither strobed nor read. It never falls except through a read, and it stays pinned once at the ceiling. Each step is bounded by the mode: at most one in frame mode, at most the parity width in bit mode. The exact popcount added for every possible mask in both modes can only be shown by the bench's scenarios. The same holds for the independence of the two lanes, the read-with-simultaneous-error case, the mode switch between frames, and the exact saturation point.

// File: rtl/bip_tally_pkg.sv
package bip_tally_pkg;

    localparam int PAR_W = 8;
    localparam int CNT_W = 16;
    localparam int N_LANES = 2;

    typedef enum logic {
        TALLY_BITS   = 1'b0,
        TALLY_FRAMES = 1'b1
    } tally_mode_e;

    typedef struct packed {
        logic [PAR_W-1:0] calc;
        logic [PAR_W-1:0] rcvd;
    } parity_pair_t;

    typedef struct packed {
        parity_pair_t pair;
        tally_mode_e  mode;
        logic         rd;
    } lane_in_t;

endpackage

// File: rtl/bip_err_mask.sv
module bip_err_mask
    import bip_tally_pkg::*;
#(
    parameter int W     = PAR_W,
    parameter int INC_W = $clog2(PAR_W + 1)
) (
    input  parity_pair_t     pair,
    input  tally_mode_e      mode,
    output logic [INC_W-1:0] inc
);

    logic [W-1:0]     mask;
    logic [INC_W-1:0] ones;

    always_comb begin
        mask = pair.calc ^ pair.rcvd;
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + INC_W'(mask[i]);
        end
        if (mode == TALLY_FRAMES) begin
            inc = INC_W'(|mask);
        end else begin
            inc = ones;
        end
    end

endmodule

// File: rtl/bip_sat_counter.sv
module bip_sat_counter #(
    parameter int CW    = 16,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_en,
    input  logic [INC_W-1:0] add_val,
    input  logic             clr,
    output logic [CW-1:0]    count
);

    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    logic [CW:0]   base;
    logic [CW:0]   sum;
    logic [CW-1:0] nxt;

    always_comb begin
        base = clr ? '0 : {1'b0, count};
        sum  = base + (CW + 1)'(add_en ? add_val : '0);
        nxt  = sum[CW] ? TOP : sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            count <= nxt;
        end
    end

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(count) == TOP && !$past(clr) && !$past(rst)) |-> count == TOP);

    // R8
    clear_bound_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> count <= CW'(2**INC_W - 1));

    // R6
    no_decrease_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && !$past(rst)) |-> count >= $past(count));

endmodule

// File: rtl/bip_err_tally.sv
module bip_err_tally
    import bip_tally_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_stb,
    input  logic [PAR_W-1:0] sec_calc,
    input  logic [PAR_W-1:0] sec_rcvd,
    input  logic [PAR_W-1:0] line_calc,
    input  logic [PAR_W-1:0] line_rcvd,
    input  logic             sec_mode,
    input  logic             line_mode,
    input  logic             sec_rd,
    input  logic             line_rd,
    output logic [CNT_W-1:0] sec_count,
    output logic [CNT_W-1:0] line_count
);

    localparam int INC_W = $clog2(PAR_W + 1);

    lane_in_t         lane_in  [N_LANES];
    logic [CNT_W-1:0] lane_cnt [N_LANES];

    always_comb begin
        lane_in[0].pair.calc = sec_calc;
        lane_in[0].pair.rcvd = sec_rcvd;
        lane_in[0].mode      = tally_mode_e'(sec_mode);
        lane_in[0].rd        = sec_rd;
        lane_in[1].pair.calc = line_calc;
        lane_in[1].pair.rcvd = line_rcvd;
        lane_in[1].mode      = tally_mode_e'(line_mode);
        lane_in[1].rd        = line_rd;
    end

    generate
        for (genvar g = 0; g < N_LANES; g++) begin : g_lane
            logic [INC_W-1:0] inc;

            bip_err_mask #(.W(PAR_W), .INC_W(INC_W)) u_mask (
                .pair (lane_in[g].pair),
                .mode (lane_in[g].mode),
                .inc  (inc)
            );

            bip_sat_counter #(.CW(CNT_W), .INC_W(INC_W)) u_cnt (
                .clk     (clk),
                .rst     (rst),
                .add_en  (frame_stb),
                .add_val (inc),
                .clr     (lane_in[g].rd),
                .count   (lane_cnt[g])
            );

            // R6
            idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (!frame_stb && !lane_in[g].rd) |=> $stable(lane_cnt[g]));

            // R4
            frame_step_chk: assert property (@(posedge clk) disable iff (rst)
                (frame_stb && !lane_in[g].rd && lane_in[g].mode == TALLY_FRAMES)
                |=> (lane_cnt[g] - $past(lane_cnt[g])) <= CNT_W'(1));

            // R3
            bit_step_chk: assert property (@(posedge clk) disable iff (rst)
                (frame_stb && !lane_in[g].rd && lane_in[g].mode == TALLY_BITS)
                |=> (lane_cnt[g] - $past(lane_cnt[g])) <= CNT_W'(PAR_W));
        end
    endgenerate

    assign sec_count  = lane_cnt[0];
    assign line_count = lane_cnt[1];

endmodule

// File: tb/bip_err_tally_test.sv
module bip_err_tally_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_stb = 1'b0;
    logic [7:0]  sec_calc = '0, sec_rcvd = '0, line_calc = '0, line_rcvd = '0;
    logic        sec_mode = 1'b0, line_mode = 1'b0, sec_rd = 1'b0, line_rd = 1'b0;
    logic [15:0] sec_count, line_count;

    int checks = 0;
    int errors = 0;
    int exp_s = 0;
    int exp_l = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bip_err_tally uut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb),
        .sec_calc(sec_calc), .sec_rcvd(sec_rcvd),
        .line_calc(line_calc), .line_rcvd(line_rcvd),
        .sec_mode(sec_mode), .line_mode(line_mode),
        .sec_rd(sec_rd), .line_rd(line_rd),
        .sec_count(sec_count), .line_count(line_count)
    );

    function automatic int ones8(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int incr(input logic [7:0] m, input logic md);
        if (md) return (m != 0) ? 1 : 0;
        return ones8(m);
    endfunction

    function automatic int sat(input int v);
        return (v > 65535) ? 65535 : v;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive one cycle from a negedge; returns at the following negedge
    task automatic step(input logic [7:0] sc, input logic [7:0] sr,
                        input logic [7:0] lc, input logic [7:0] lr,
                        input logic sm, input logic lm,
                        input logic st, input logic srd, input logic lrd);
        sec_calc = sc; sec_rcvd = sr; line_calc = lc; line_rcvd = lr;
        sec_mode = sm; line_mode = lm; frame_stb = st; sec_rd = srd; line_rd = lrd;
        #1;
        if (srd) chk("R8 sec read value", int'(sec_count), exp_s);
        if (lrd) chk("R8 line read value", int'(line_count), exp_l);
        if (st && !srd) chk("R10 sec not early", int'(sec_count), exp_s);
        @(posedge clk);
        @(negedge clk);
        frame_stb = 1'b0; sec_rd = 1'b0; line_rd = 1'b0;
        if (srd) exp_s = 0;
        if (lrd) exp_l = 0;
        if (st) begin
            exp_s = sat(exp_s + incr(sc ^ sr, sm));
            exp_l = sat(exp_l + incr(lc ^ lr, lm));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 sec reset", int'(sec_count), 0);
        chk("R1 line reset", int'(line_count), 0);
        rst = 1'b0;
        @(negedge clk);

        // exhaustive mask sweep, both modes, lanes in opposite modes
        for (int md = 0; md < 2; md++) begin
            for (int m = 0; m < 256; m++) begin
                logic [7:0] sc, lc;
                sc = 8'(m * 37 + 11);
                lc = 8'(m * 91 + 5);
                step(sc, sc ^ 8'(m), lc, lc ^ 8'(255 - m), md[0], ~md[0], 1'b1, 1'b0, 1'b0);
                if (m == 0)
                    chk("R2 zero mask sec", int'(sec_count), exp_s);
                else if (md == 0)
                    chk("R3 sec bit tally", int'(sec_count), exp_s);
                else
                    chk("R4 sec frame tally", int'(sec_count), exp_s);
                chk("R5 line lane", int'(line_count), exp_l);
            end
            step(0, 0, 0, 0, 0, 0, 1'b0, 1'b1, 1'b1);
            chk("R8 sec cleared", int'(sec_count), 0);
            chk("R8 line cleared", int'(line_count), 0);
        end

        // accumulate, then idle with changing inputs and no strobe
        step(8'h00, 8'h3C, 8'hFF, 8'h0F, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 20; k++) begin
            step(8'(k * 7), 8'(k * 13 + 1), 8'(k), 8'(~k), k[0], k[1], 1'b0, 1'b0, 1'b0);
            chk("R6 sec idle hold", int'(sec_count), 4);
            chk("R6 line idle hold", int'(line_count), 4);
        end

        // read with a simultaneous error: cleared then incremented
        step(8'hAA, 8'h55, 8'h01, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        chk("R8 sec read plus error", int'(sec_count), 8);
        chk("R8 line read plus error", int'(line_count), 1);
        chk("R8 model sec", exp_s, 8);

        // mode switch between frames
        step(0, 0, 0, 0, 0, 0, 1'b0, 1'b1, 1'b1);
        step(8'h0F, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 bit mode before switch", int'(sec_count), 4);
        step(8'h0F, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 frame mode after switch", int'(sec_count), 5);
        step(8'h0F, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 back to bit mode", int'(sec_count), 9);

        // saturation: sec adds 8 per frame, line adds 1 per frame
        step(0, 0, 0, 0, 0, 0, 1'b0, 1'b1, 1'b1);
        for (int f = 0; f < 8200; f++) begin
            step(8'hFF, 8'h00, 8'h80, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
            if (f == 8190) chk("R7 sec below ceiling", int'(sec_count), 65528);
        end
        chk("R7 sec saturated", int'(sec_count), 65535);
        chk("R5 line unaffected by sec ceiling", int'(line_count), 8200);
        step(8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R7 sec stays at ceiling", int'(sec_count), 65535);
        step(8'h03, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R8 clear from ceiling", int'(sec_count), 2);

        // reset mid-run
        rst = 1'b1;
        @(negedge clk);
        chk("R1 sec reset again", int'(sec_count), 0);
        chk("R1 line reset again", int'(line_count), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule